// File: doc/BRIEF.md
# Nested hardware loop controller

This block provides zero-overhead loops for an in-order core. When the core executes a loop instruction, it presents that instruction's PC, a body length counted in instructions and an iteration count. The block keeps one level per active loop on a small stack. Each level holds the body's first address, the address just past the body, the restarts still to come and the total count.

After every retired instruction the core presents its sequential next PC. Only the innermost level is compared against it. On a match the block asks, in the same cycle, for a jump back to the body start. It also reports which iteration is about to begin, so that a trace can log it. An iteration count of zero skips the body. A count of one is a no-op. A push that finds no free level sets a sticky error flag.

Top module: `hwloop_ctrl`

## Requirements
- R1: A loop request with count of at least 2 and a nonzero body pushes a level: start = PC+4, end = PC+4+4*body. Later steps whose next PC differs from the end do not redirect.
- R2: A request with count 0 and a nonzero body raises redirect_o in the same cycle, with target PC+4+4*body and iter_idx_o = 0. The stack is left unchanged.
- R3: A request with count 1 redirects nothing and pushes nothing.
- R4: A request with body 0 is dropped: no push and no skip redirect.
- R5: Only the innermost level is compared. A next PC that equals an outer level's end address does not redirect while an inner level is active.
- R6: A level with count N redirects N-1 times to its start. It is popped on the last of those redirects, and after that the next outer level is innermost.
- R7: On a back-edge redirect, iter_idx_o equals the total count minus the restarts left after the decrement. Successive back edges give 2, 3, ..., N, for any 32-bit count.
- R8: A push while all DEPTH levels are in use (after any pop in that cycle) is dropped. It sets overflow_o from the next cycle on, and overflow_o stays set until reset.
- R9: When a request and a step arrive in the same cycle, the step is evaluated on the stack as it was before the push. A back-edge redirect wins over a skip redirect, and a level popped in that cycle frees room for the push.
- R10: While reset is asserted, overflow_o is cleared and the stack is emptied.
- R11: With step_valid_i low, no back-edge comparison takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | A loop instruction executes this cycle |
| start_pc_i | input | 32 | PC of the loop instruction |
| start_iters_i | input | 32 | Iteration count, unsigned |
| start_body_i | input | 12 | Body length in instructions |
| step_valid_i | input | 1 | An instruction retires this cycle |
| step_next_pc_i | input | 32 | Sequential next PC of the retiring instruction |
| redirect_o | output | 1 | Next PC must be replaced |
| redirect_pc_o | output | 32 | Replacement PC |
| iter_idx_o | output | 32 | 1-based iteration being entered on a back edge, else 0 |
| overflow_o | output | 1 | Sticky stack overflow error |

## Verification
redirect_o, redirect_pc_o and iter_idx_o are combinational from the current inputs and the stack registers. They are therefore due in the same cycle as the request or step. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. A push, pop or decrement only shows up in the cycle after its edge, and overflow_o rises one cycle after the rejected push. Checks on those results are made on the following falling edge.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 32;
  localparam int BODY_W = 12;

  typedef struct packed {
    logic [ADDR_W-1:0] start_pc;
    logic [ADDR_W-1:0] end_pc;
    logic [CNT_W-1:0]  rem;
    logic [CNT_W-1:0]  total;
  } loop_lvl_t;
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic            dec_i,
  input  logic            push_i,
  input  loop_lvl_t       push_lvl_i,
  output loop_lvl_t       top_o,
  output logic            top_valid_o,
  output logic            push_drop_o,
  output logic [LW-1:0]   level_o
);
  loop_lvl_t       lvl_q [DEPTH];
  logic [LW-1:0]   cnt_q, cnt_pop;
  logic            room, push_ok;

  // pop is applied before the push so a freed slot can be reused in one cycle
  assign cnt_pop     = (pop_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
  assign room        = cnt_pop < LW'(DEPTH);
  assign push_ok     = push_i && room;
  assign push_drop_o = push_i && !room;
  assign top_valid_o = cnt_q != '0;
  assign level_o     = cnt_q;

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == LW'(i + 1)) top_o = lvl_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else begin
      cnt_q <= cnt_pop + LW'(push_ok);
      for (int i = 0; i < DEPTH; i++) begin
        if (push_ok && cnt_pop == LW'(i))
          lvl_q[i] <= push_lvl_i;
        else if (dec_i && cnt_q == LW'(i + 1))
          lvl_q[i].rem <= lvl_q[i].rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hwloop_step.sv
module hwloop_step
  import hwloop_pkg::*;
(
  input  logic              step_valid_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  loop_lvl_t         top_i,
  input  logic              top_valid_i,
  output logic              hit_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [CNT_W-1:0]  idx_o
);
  logic [CNT_W-1:0] rem_dec;

  assign rem_dec  = top_i.rem - 1'b1;
  assign hit_o    = step_valid_i && top_valid_i && (next_pc_i == top_i.end_pc);
  assign last_o   = rem_dec == '0;
  assign target_o = top_i.start_pc;
  assign idx_o    = top_i.total - rem_dec;
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_valid_i,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic [CNT_W-1:0]  start_iters_i,
  input  logic [BODY_W-1:0] start_body_i,
  input  logic              step_valid_i,
  input  logic [ADDR_W-1:0] step_next_pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [CNT_W-1:0]  iter_idx_o,
  output logic              overflow_o
);
  loop_lvl_t         top_lvl, new_lvl;
  logic              top_valid, push_drop, step_hit, step_last;
  logic              req_ok, skip, push_req;
  logic [ADDR_W-1:0] body_start, body_end, back_pc;
  logic [CNT_W-1:0]  back_idx;
  logic [LW-1:0]     level_w;
  logic              ovf_q;

  assign req_ok     = start_valid_i && (start_body_i != '0);
  assign skip       = req_ok && (start_iters_i == '0);
  assign push_req   = req_ok && (start_iters_i > CNT_W'(1));
  assign body_start = start_pc_i + ADDR_W'(4);
  assign body_end   = body_start + ADDR_W'({start_body_i, 2'b00});

  assign new_lvl = '{start_pc: body_start, end_pc: body_end,
                     rem: start_iters_i - 1'b1, total: start_iters_i};

  hwloop_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (step_hit && step_last),
    .dec_i       (step_hit && !step_last),
    .push_i      (push_req),
    .push_lvl_i  (new_lvl),
    .top_o       (top_lvl),
    .top_valid_o (top_valid),
    .push_drop_o (push_drop),
    .level_o     (level_w)
  );

  hwloop_step u_step (
    .step_valid_i (step_valid_i),
    .next_pc_i    (step_next_pc_i),
    .top_i        (top_lvl),
    .top_valid_i  (top_valid),
    .hit_o        (step_hit),
    .last_o       (step_last),
    .target_o     (back_pc),
    .idx_o        (back_idx)
  );

  // back edge has priority over a zero-count skip
  assign redirect_o    = step_hit || skip;
  assign redirect_pc_o = step_hit ? back_pc : body_end;
  assign iter_idx_o    = step_hit ? back_idx : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_q | push_drop;
  end
  assign overflow_o = ovf_q;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk
  import hwloop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_valid_i,
  input logic [CNT_W-1:0]  start_iters_i,
  input logic [BODY_W-1:0] start_body_i,
  input logic              step_valid_i,
  input logic              redirect_o,
  input logic [CNT_W-1:0]  iter_idx_o,
  input logic              overflow_o,
  input logic [LW-1:0]     level_i,
  input logic              hit_i
);
  a_r3_single_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_iters_i == CNT_W'(1) && !hit_i |-> !redirect_o);

  a_r4_empty_body_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_body_i == '0 && !hit_i |-> !redirect_o);

  a_r11_idle_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_valid_i && !start_valid_i |-> !redirect_o);

  a_r8_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r8_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(start_valid_i) && $past(level_i) == LW'(DEPTH));

  a_r6_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LW'(DEPTH));

  a_r7_idx_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> iter_idx_o >= CNT_W'(2));

  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_iters_i > CNT_W'(1) && start_body_i != '0 && !hit_i
      && level_i < LW'(DEPTH) |=> level_i == $past(level_i) + 1'b1);
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_valid_i (start_valid_i),
  .start_iters_i (start_iters_i),
  .start_body_i  (start_body_i),
  .step_valid_i  (step_valid_i),
  .redirect_o    (redirect_o),
  .iter_idx_o    (iter_idx_o),
  .overflow_o    (overflow_o),
  .level_i       (level_w),
  .hit_i         (step_hit)
);

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_valid_i = 1'b0;
  logic [31:0] start_pc_i = '0;
  logic [31:0] start_iters_i = '0;
  logic [11:0] start_body_i = '0;
  logic        step_valid_i = 1'b0;
  logic [31:0] step_next_pc_i = '0;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic [31:0] iter_idx_o;
  logic        overflow_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hwloop_ctrl #(.DEPTH(8)) dut_i (.*);

  typedef struct packed {
    logic        sv;
    logic [31:0] pc;
    logic [31:0] it;
    logic [11:0] bd;
    logic        tv;
    logic [31:0] npc;
    logic        er;
    logic [31:0] epc;
    logic [31:0] eidx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h100, 32'd3, 12'd2, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd1},  // R1
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h108, 1'b0, 32'h0,   32'd0, 8'd1},  // R1
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h10C, 1'b1, 32'h104, 32'd2, 8'd7},  // R7
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h108, 1'b0, 32'h0,   32'd0, 8'd1},  // R1
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h10C, 1'b1, 32'h104, 32'd3, 8'd7},  // R7
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h10C, 1'b0, 32'h0,   32'd0, 8'd6},  // R6
    '{1'b1, 32'h200, 32'd0, 12'd5, 1'b0, 32'h0,   1'b1, 32'h218, 32'd0, 8'd2},  // R2
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h218, 1'b0, 32'h0,   32'd0, 8'd2},  // R2
    '{1'b1, 32'h300, 32'd1, 12'd1, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd3},  // R3
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h308, 1'b0, 32'h0,   32'd0, 8'd3},  // R3
    '{1'b1, 32'h400, 32'd2, 12'd4, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd5},  // R5
    '{1'b1, 32'h404, 32'd2, 12'd1, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd5},  // R5
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h414, 1'b0, 32'h0,   32'd0, 8'd5},  // R5
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h40C, 1'b1, 32'h408, 32'd2, 8'd5},  // R5
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h40C, 1'b0, 32'h0,   32'd0, 8'd6},  // R6
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h414, 1'b1, 32'h404, 32'd2, 8'd6},  // R6
    '{1'b1, 32'h500, 32'd3, 12'd0, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd4},  // R4
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h504, 1'b0, 32'h0,   32'd0, 8'd4},  // R4
    '{1'b1, 32'h500, 32'd0, 12'd0, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd4},  // R4
    '{1'b1, 32'h600, 32'd2, 12'd1, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd9},  // R9
    '{1'b1, 32'h604, 32'd0, 12'd3, 1'b1, 32'h608, 1'b1, 32'h604, 32'd2, 8'd9},  // R9
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h608, 1'b0, 32'h0,   32'd0, 8'd9},  // R9
    '{1'b1, 32'h700, 32'd2, 12'd1, 1'b0, 32'h0,   1'b0, 32'h0,   32'd0, 8'd11}, // R11
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b0, 32'h708, 1'b0, 32'h0,   32'd0, 8'd11}, // R11
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h708, 1'b1, 32'h704, 32'd2, 8'd11}, // R11
    '{1'b1, 32'h800, 32'hFFFF_FFFF, 12'd1, 1'b0, 32'h0, 1'b0, 32'h0, 32'd0, 8'd7}, // R7
    '{1'b0, 32'h0,   32'd0, 12'd0, 1'b1, 32'h808, 1'b1, 32'h804, 32'd2, 8'd7}   // R7
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus on the falling edge, settle before sampling
  task automatic drive(input bit sv, input logic [31:0] pc, input logic [31:0] it,
                       input logic [11:0] bd, input bit tv, input logic [31:0] npc);
    @(negedge clk_i);
    start_valid_i  = sv;
    start_pc_i     = pc;
    start_iters_i  = it;
    start_body_i   = bd;
    step_valid_i   = tv;
    step_next_pc_i = npc;
    #1;
  endtask

  task automatic expect_redir(input string req, input bit er, input logic [31:0] epc,
                              input logic [31:0] eidx);
    chk(redirect_o == er, req, {31'b0, redirect_o}, {31'b0, er});
    if (er) begin
      chk(redirect_pc_o == epc, req, redirect_pc_o, epc);
      chk(iter_idx_o == eidx, req, iter_idx_o, eidx);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_valid_i = 1'b0;
    step_valid_i = 1'b0;
    #1;
    chk(overflow_o == 1'b0, "R10", {31'b0, overflow_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fill8();
    for (int i = 0; i < 8; i++)
      drive(1'b1, 32'h1000 + 32'(i) * 32'h100, 32'd2, 12'd1, 1'b0, 32'h0);
  endtask

  initial begin
    do_reset();
    drive(1'b0, '0, '0, '0, 1'b1, 32'h0);
    expect_redir("R10", 1'b0, '0, '0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].sv, VEC[v].pc, VEC[v].it, VEC[v].bd, VEC[v].tv, VEC[v].npc);
      expect_redir($sformatf("R%0d vec%0d", VEC[v].req, v), VEC[v].er, VEC[v].epc,
                   VEC[v].eidx);
    end
    drive(1'b0, '0, '0, '0, 1'b0, '0);
    chk(overflow_o == 1'b0, "R8", {31'b0, overflow_o}, 32'd0);

    // R8: push onto a full stack is dropped and sets a sticky flag
    do_reset();
    fill8();
    drive(1'b0, '0, '0, '0, 1'b0, '0);
    chk(overflow_o == 1'b0, "R8", {31'b0, overflow_o}, 32'd0);
    drive(1'b1, 32'h3000, 32'd2, 12'd1, 1'b0, 32'h0);
    drive(1'b0, '0, '0, '0, 1'b1, 32'h3008);
    chk(overflow_o == 1'b1, "R8", {31'b0, overflow_o}, 32'd1);
    expect_redir("R8", 1'b0, '0, '0);
    drive(1'b0, '0, '0, '0, 1'b1, 32'h1708);
    expect_redir("R8", 1'b1, 32'h1704, 32'd2);
    drive(1'b0, '0, '0, '0, 1'b1, 32'h1608);
    expect_redir("R8", 1'b1, 32'h1604, 32'd2);
    repeat (3) drive(1'b0, '0, '0, '0, 1'b0, '0);
    chk(overflow_o == 1'b1, "R8", {31'b0, overflow_o}, 32'd1);

    // R10: reset clears the flag and empties the stack
    do_reset();
    drive(1'b0, '0, '0, '0, 1'b1, 32'h1508);
    expect_redir("R10", 1'b0, '0, '0);
    chk(overflow_o == 1'b0, "R10", {31'b0, overflow_o}, 32'd0);

    // R9: pop and push in one cycle on a full stack
    fill8();
    drive(1'b1, 32'h2000, 32'd2, 12'd1, 1'b1, 32'h1708);
    expect_redir("R9", 1'b1, 32'h1704, 32'd2);
    drive(1'b0, '0, '0, '0, 1'b1, 32'h2008);
    chk(overflow_o == 1'b0, "R9", {31'b0, overflow_o}, 32'd0);
    expect_redir("R9", 1'b1, 32'h2004, 32'd2);
    drive(1'b0, '0, '0, '0, 1'b1, 32'h1608);
    expect_redir("R9", 1'b1, 32'h1604, 32'd2);

    drive(1'b0, '0, '0, '0, 1'b0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule